// File: doc/BRIEF.md
# Dual-CAS DRAM Strobe Decoder

This block is the device-side control front end of a page-mode DRAM with two byte-lane column strobes. A fast clock samples the asynchronous-style pins: row strobe, lower and upper column strobes, write enable and output enable. The block turns them into standby, word or byte reads, word or byte writes, read-modify-write, row-only refresh and strobe-first refresh cycles. It latches the row address when the row strobe falls. The internal column strobe is formed from the two lane strobes: it becomes active when the first lane falls and stays active until the last lane rises. The column address is latched on the falling edge of that internal strobe.

A small behavioural array sits beside the block. The block presents a read address and receives the read word combinationally. It issues registered write commands with per-lane strobes. It also reports every row activation: a refresh of either the external row or the internal refresh row. Read data is held on a lane after its column strobe rises, in extended-data-out style. The held data is released at the next internal column-strobe fall, when output enable goes high, or when every strobe is high. A 10-bit refresh row counter is advanced by each strobe-first refresh and can be read on a port.

Top module: `dcs_strobe_front`

## Requirements
- R1: The column address is latched only on the first lane strobe fall of a column cycle. A second lane that falls while the other is still low uses the column already latched and not the current address.
- R2: The row address is latched when the row strobe falls with both lane strobes high. One cycle after that sample, `act_pulse` is high for exactly one cycle, with `act_cbr`=0 and `act_row` equal to the row.
- R3: In an access cycle, a lane is sampled low with write enable high and output enable low. One cycle later that lane's bit of `dq_drv` is 1 (bit 0 = lower lane, dq bits 7:0; bit 1 = upper lane, dq bits 15:8), and its byte of `dq_out` holds the array word at the latched row and column.
- R4: A write is triggered when a lane is low and write enable is low, at the later of that lane's fall and the fall of write enable. One cycle after the trigger, `arr_wr_en`=1, `arr_wr_strb` marks exactly the lanes that were triggered, `arr_wr_row` and `arr_wr_col` hold the latched addresses, and `arr_wr_data` equals `dq_in`.
- R5: If any lane strobe is low when the row strobe falls, the cycle is a refresh. `act_pulse` and `act_cbr` are 1, `act_row` equals the counter value before the increment, no lane drives, and no write is issued.
- R6: With the row strobe low and both lane strobes high, no lane drives and no write is issued (row-only refresh).
- R7: Read data on a lane stays driven and unchanged after its strobe rises. It is replaced at the next internal column-strobe fall.
- R8: When the row strobe and both lane strobes are sampled high, one cycle later `dq_drv`=0 and `arr_wr_en`=0.
- R9: In a read-modify-write, write enable falls while the lanes are still low after a read. This issues a write to the column latched for the read, in the same row cycle.
- R10: `ref_count` starts at 0 after reset, increases by one per strobe-first refresh and wraps from 1023 to 0.
- R11: Output enable sampled high makes `dq_drv` 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower lane column strobe, active low |
| ucas_n | input | 1 | Upper lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the pins |
| dq_out | output | 16 | Read data toward the pins |
| dq_drv | output | 2 | Per-lane output drive enable |
| arr_rd_row | output | 10 | Array read row |
| arr_rd_col | output | 10 | Array read column |
| arr_rd_data | input | 16 | Array read word |
| arr_wr_en | output | 1 | Array write command |
| arr_wr_row | output | 10 | Array write row |
| arr_wr_col | output | 10 | Array write column |
| arr_wr_data | output | 16 | Array write word |
| arr_wr_strb | output | 2 | Array write lane strobes |
| act_pulse | output | 1 | Row activation event |
| act_cbr | output | 1 | Activation came from the internal counter |
| act_row | output | 10 | Row activated |
| ref_count | output | 10 | Internal refresh row counter |

## Verification
The assertions assume that the pins change only away from the sampling edge and stay stable for at least one clock, so that every edge is seen as one clean sampled transition. They also assume that reset holds all strobes high, so no edge appears spuriously in the first cycle. The bench drives every pin just after the falling clock edge and holds each step for a full cycle. Its directed sequences and random sequences always return all strobes high between row cycles, which keeps the stimulus within these assumptions.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_ACCESS  = 2'd1,
    MODE_REFRESH = 2'd2
  } dcs_mode_e;

  // Lane i of a word: bits [i*8 +: 8] for 8-bit lanes.
  function automatic logic [7:0] lane_byte(input logic [15:0] w, input int i);
    return w[i*8 +: 8];
  endfunction
endpackage

// File: rtl/dcs_edge_sampler.sv
module dcs_edge_sampler #(
  parameter int NLANE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [NLANE-1:0] cas_n,
  input  logic             we_n,
  output logic             ras_fall,
  output logic [NLANE-1:0] lane_low,
  output logic [NLANE-1:0] lane_fall,
  output logic             cas_act,
  output logic             cas_fall,
  output logic             we_fall
);
  logic             ras_q;
  logic [NLANE-1:0] cas_q;
  logic             we_q;
  logic             cas_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_q     <= '1;
      we_q      <= 1'b1;
      cas_act_q <= 1'b0;
    end else begin
      ras_q     <= ras_n;
      cas_q     <= cas_n;
      we_q      <= we_n;
      cas_act_q <= cas_act;
    end
  end

  assign lane_low  = ~cas_n;
  assign lane_fall = ~cas_n & cas_q;
  assign cas_act   = |lane_low;
  assign cas_fall  = cas_act & ~cas_act_q;
  assign ras_fall  = ~ras_n & ras_q;
  assign we_fall   = ~we_n & we_q;
endmodule

// File: rtl/dcs_byte_lane.sv
module dcs_byte_lane #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          kill,
  input  logic          lane_low,
  input  logic          lane_fall,
  input  logic          cas_fall,
  input  logic          we_n,
  input  logic          we_fall,
  input  logic          oe_n,
  input  logic [LW-1:0] rd_byte,
  output logic          wr_hit,
  output logic          drv,
  output logic [LW-1:0] dout
);
  logic rd_now;

  assign wr_hit = acc & lane_low & ~we_n & (lane_fall | we_fall);
  assign rd_now = acc & lane_low & we_n & ~oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv  <= 1'b0;
      dout <= '0;
    end else if (kill) begin
      drv <= 1'b0;
    end else if (rd_now) begin
      drv  <= 1'b1;
      dout <= rd_byte;
    end else if (cas_fall | oe_n) begin
      drv <= 1'b0;
    end
  end
endmodule

// File: rtl/dcs_refresh_ctr.sv
module dcs_refresh_ctr #(
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [RW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= count + 1'b1;
  end
endmodule

// File: rtl/dcs_strobe_front.sv
module dcs_strobe_front #(
  parameter int AW    = 10,
  parameter int NLANE = 2,
  parameter int LW    = 8,
  localparam int DW   = NLANE * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             lcas_n,
  input  logic             ucas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic [NLANE-1:0] dq_drv,
  output logic [AW-1:0]    arr_rd_row,
  output logic [AW-1:0]    arr_rd_col,
  input  logic [DW-1:0]    arr_rd_data,
  output logic             arr_wr_en,
  output logic [AW-1:0]    arr_wr_row,
  output logic [AW-1:0]    arr_wr_col,
  output logic [DW-1:0]    arr_wr_data,
  output logic [NLANE-1:0] arr_wr_strb,
  output logic             act_pulse,
  output logic             act_cbr,
  output logic [AW-1:0]    act_row,
  output logic [AW-1:0]    ref_count
);
  import dcs_pkg::*;

  logic [NLANE-1:0] cas_n_v;
  logic             ras_fall, cas_act, cas_fall, we_fall;
  logic [NLANE-1:0] lane_low, lane_fall, wr_hit;
  dcs_mode_e        mode_q;
  logic [AW-1:0]    row_q, col_q, col_eff;
  logic             acc, refresh_start, kill, standby;

  // Two lanes map onto the two named strobe pins; lane 0 is the lower byte.
  assign cas_n_v = NLANE'({ucas_n, lcas_n});

  dcs_edge_sampler #(.NLANE(NLANE)) u_edges (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n_v), .we_n(we_n),
    .ras_fall(ras_fall), .lane_low(lane_low), .lane_fall(lane_fall),
    .cas_act(cas_act), .cas_fall(cas_fall), .we_fall(we_fall)
  );

  assign refresh_start = ras_fall & cas_act;
  assign acc           = (mode_q == MODE_ACCESS) & ~ras_n;
  assign standby       = ras_n & ~cas_act;
  assign kill          = standby | refresh_start | (mode_q == MODE_REFRESH);
  assign col_eff       = cas_fall ? addr : col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      if (ras_n)         mode_q <= MODE_IDLE;
      else if (ras_fall) mode_q <= cas_act ? MODE_REFRESH : MODE_ACCESS;
      if (ras_fall && !cas_act) row_q <= addr;
      if (acc && cas_fall)      col_q <= addr;
    end
  end

  assign arr_rd_row = row_q;
  assign arr_rd_col = col_eff;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    dcs_byte_lane #(.LW(LW)) u_lane (
      .clk(clk), .rst_n(rst_n), .acc(acc), .kill(kill),
      .lane_low(lane_low[i]), .lane_fall(lane_fall[i]), .cas_fall(cas_fall),
      .we_n(we_n), .we_fall(we_fall), .oe_n(oe_n),
      .rd_byte(arr_rd_data[i*LW +: LW]),
      .wr_hit(wr_hit[i]), .drv(dq_drv[i]), .dout(dq_out[i*LW +: LW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_wr_en   <= 1'b0;
      arr_wr_row  <= '0;
      arr_wr_col  <= '0;
      arr_wr_data <= '0;
      arr_wr_strb <= '0;
    end else begin
      arr_wr_en   <= |wr_hit;
      arr_wr_strb <= wr_hit;
      if (|wr_hit) begin
        arr_wr_row  <= row_q;
        arr_wr_col  <= col_eff;
        arr_wr_data <= dq_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_pulse <= 1'b0;
      act_cbr   <= 1'b0;
      act_row   <= '0;
    end else begin
      act_pulse <= ras_fall;
      if (ras_fall) begin
        act_cbr <= cas_act;
        act_row <= cas_act ? ref_count : addr;
      end
    end
  end

  dcs_refresh_ctr #(.RW(AW)) u_ref (
    .clk(clk), .rst_n(rst_n), .step(refresh_start), .count(ref_count)
  );
endmodule

// File: rtl/dcs_strobe_front_chk.sv
module dcs_strobe_front_chk #(
  parameter int AW    = 10,
  parameter int NLANE = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             lcas_n,
  input logic             ucas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [NLANE-1:0] dq_drv,
  input logic             arr_wr_en,
  input logic [NLANE-1:0] arr_wr_strb,
  input logic             act_pulse,
  input logic             act_cbr,
  input logic [AW-1:0]    act_row,
  input logic [AW-1:0]    ref_count
);
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n && lcas_n && ucas_n) |-> (dq_drv == '0 && !arr_wr_en)); // R8

  AST_REFRESH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pulse && act_cbr) |-> (ref_count == AW'(act_row + 1'b1))); // R10

  AST_REFRESH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pulse && act_cbr) |-> (dq_drv == '0 && !arr_wr_en)); // R5

  AST_ACT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |=> !act_pulse); // R2

  AST_WRITE_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> ($past(!ras_n && !we_n) && arr_wr_strb != '0)); // R4

  AST_LOW_DRIVE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_drv[0]) |-> $past(!lcas_n && !oe_n && we_n && !ras_n)); // R3

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n) |-> (dq_drv == '0)); // R11
endmodule

bind dcs_strobe_front dcs_strobe_front_chk #(.AW(AW), .NLANE(NLANE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
  .we_n(we_n), .oe_n(oe_n), .dq_drv(dq_drv), .arr_wr_en(arr_wr_en),
  .arr_wr_strb(arr_wr_strb), .act_pulse(act_pulse), .act_cbr(act_cbr),
  .act_row(act_row), .ref_count(ref_count)
);

// File: tb/tb_dcs_strobe_front.sv
`timescale 1ns/1ps
module tb_dcs_strobe_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, arr_rd_data, arr_wr_data;
  logic [1:0]  dq_drv, arr_wr_strb;
  logic [9:0]  arr_rd_row, arr_rd_col, arr_wr_row, arr_wr_col, act_row, ref_count;
  logic        arr_wr_en, act_pulse, act_cbr;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int exp_ref = 0;

  logic [15:0] amem   [0:255];
  logic [15:0] shadow [0:255];

  always #2 clk = ~clk;

  dcs_strobe_front dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_drv(dq_drv), .arr_rd_row(arr_rd_row), .arr_rd_col(arr_rd_col),
    .arr_rd_data(arr_rd_data), .arr_wr_en(arr_wr_en), .arr_wr_row(arr_wr_row),
    .arr_wr_col(arr_wr_col), .arr_wr_data(arr_wr_data), .arr_wr_strb(arr_wr_strb),
    .act_pulse(act_pulse), .act_cbr(act_cbr), .act_row(act_row), .ref_count(ref_count)
  );

  function automatic logic [15:0] pat(input int r, input int c);
    return 16'(r * 16'h0125 + c * 16'h0B07 + 16'h5A3C);
  endfunction

  function automatic int idx(input int r, input int c);
    return (r % 16) * 16 + (c % 16);
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                        input logic [1:0] m);
    return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
  endfunction

  assign arr_rd_data = amem[{arr_rd_row[3:0], arr_rd_col[3:0]}];

  always @(posedge clk) begin
    if (arr_wr_en)
      amem[{arr_wr_row[3:0], arr_wr_col[3:0]}] <=
        merge(amem[{arr_wr_row[3:0], arr_wr_col[3:0]}], arr_wr_data, arr_wr_strb);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_all();
    ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1;
    step();
  endtask

  task automatic chk_read(input int r, input int c, input logic [1:0] m, input string tag);
    logic [15:0] e;
    e = shadow[idx(r, c)];
    chk(dq_drv == m, {tag, " drv"}, dq_drv, m);
    if (m[0]) chk(dq_out[7:0] == e[7:0], {tag, " low"}, dq_out[7:0], e[7:0]);
    if (m[1]) chk(dq_out[15:8] == e[15:8], {tag, " high"}, dq_out[15:8], e[15:8]);
  endtask

  task automatic do_read(input int r, input int c, input logic [1:0] m);
    ras_n = 0; addr = 10'(r); step();
    addr = 10'(c); we_n = 1; oe_n = 0; lcas_n = ~m[0]; ucas_n = ~m[1]; step();
    chk_read(r, c, m, "R3 read");
    lcas_n = 1; ucas_n = 1; step();
    chk_read(r, c, m, "R7 hold after strobe rise");
    ras_n = 1; step();
    chk(dq_drv == 2'b00, "R8 standby release", dq_drv, 0);
    oe_n = 1; step();
  endtask

  task automatic chk_write(input int r, input int c, input logic [1:0] m,
                           input logic [15:0] d, input string tag);
    chk(arr_wr_en == 1'b1, {tag, " en"}, arr_wr_en, 1);
    chk(arr_wr_strb == m, {tag, " strb"}, arr_wr_strb, m);
    chk(arr_wr_row == 10'(r), {tag, " row"}, arr_wr_row, r);
    chk(arr_wr_col == 10'(c), {tag, " col"}, arr_wr_col, c);
    chk(merge(16'h0, arr_wr_data, m) == merge(16'h0, d, m), {tag, " data"},
        arr_wr_data, d);
    shadow[idx(r, c)] = merge(shadow[idx(r, c)], d, m);
  endtask

  task automatic do_write(input int r, input int c, input logic [1:0] m,
                          input logic [15:0] d, input bit late);
    ras_n = 0; oe_n = 1; addr = 10'(r); step();
    addr = 10'(c); dq_in = d; we_n = late; lcas_n = ~m[0]; ucas_n = ~m[1]; step();
    if (late) begin
      chk(arr_wr_en == 1'b0, "R4 no write before enable", arr_wr_en, 0);
      we_n = 0; step();
    end
    chk_write(r, c, m, d, "R4 write");
    step();
    chk(arr_wr_en == 1'b0, "R4 single write", arr_wr_en, 0);
    idle_all();
  endtask

  task automatic do_cbr(input bit upper, input bit check);
    if (upper) ucas_n = 0; else lcas_n = 0;
    step();
    ras_n = 0; addr = 10'h3FF; step();
    if (check) begin
      chk(act_pulse && act_cbr, "R5 refresh event", {act_pulse, act_cbr}, 3);
      chk(act_row == 10'(exp_ref), "R5 refresh row", act_row, exp_ref);
      chk(dq_drv == 2'b00 && !arr_wr_en, "R5 silent", {dq_drv, arr_wr_en}, 0);
    end
    exp_ref = (exp_ref + 1) % 1024;
    idle_all();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      amem[i]   = pat(i / 16, i % 16);
      shadow[i] = pat(i / 16, i % 16);
    end
    void'($urandom(32'h1D2C_0A07));
    repeat (3) step();
    rst_n = 1; step();

    chk(dq_drv == 2'b00 && !arr_wr_en && !act_pulse, "R8 reset quiet",
        {dq_drv, arr_wr_en, act_pulse}, 0);
    chk(ref_count == 10'd0, "R10 reset count", ref_count, 0);

    // Row-only refresh
    ras_n = 0; addr = 10'h2A5; step();
    chk(act_pulse && !act_cbr, "R2 activation", {act_pulse, act_cbr}, 2);
    chk(act_row == 10'h2A5, "R2 row", act_row, 10'h2A5);
    step();
    chk(!act_pulse, "R2 single pulse", act_pulse, 0);
    chk(dq_drv == 2'b00 && !arr_wr_en, "R6 row-only silent", {dq_drv, arr_wr_en}, 0);
    idle_all();

    // Directed reads and writes
    do_read(3, 5, 2'b11);
    do_read(4, 6, 2'b01);
    do_read(7, 9, 2'b10);
    do_write(2, 8, 2'b11, 16'hBEEF, 1'b0);
    do_write(2, 9, 2'b10, 16'hA1C3, 1'b1);
    do_read(2, 8, 2'b11);
    do_read(2, 9, 2'b11);

    // Staggered lanes: the column follows the first falling lane
    ras_n = 0; addr = 10'd6; step();
    addr = 10'd1; dq_in = 16'h1357; we_n = 0; lcas_n = 0; step();
    chk_write(6, 1, 2'b01, 16'h1357, "R1 first lane");
    addr = 10'd12; dq_in = 16'h9BDF; ucas_n = 0; step();
    chk_write(6, 1, 2'b10, 16'h9BDF, "R1 second lane keeps column");
    idle_all();
    do_read(6, 1, 2'b11);
    do_read(6, 12, 2'b11);

    // Read-modify-write
    ras_n = 0; addr = 10'd5; step();
    addr = 10'd14; oe_n = 0; we_n = 1; lcas_n = 0; ucas_n = 0; step();
    chk_read(5, 14, 2'b11, "R9 read phase");
    addr = 10'd3; oe_n = 1; step();
    chk(dq_drv == 2'b00, "R11 output enable release", dq_drv, 0);
    dq_in = 16'hC0DE; we_n = 0; step();
    chk_write(5, 14, 2'b11, 16'hC0DE, "R9 modify write");
    idle_all();
    do_read(5, 14, 2'b11);

    // Extended hold until next column fall
    ras_n = 0; addr = 10'd9; step();
    addr = 10'd2; oe_n = 0; lcas_n = 0; ucas_n = 0; step();
    lcas_n = 1; ucas_n = 1; addr = 10'd11; step();
    chk_read(9, 2, 2'b11, "R7 held");
    step();
    chk_read(9, 2, 2'b11, "R7 still held");
    lcas_n = 0; ucas_n = 0; step();
    chk_read(9, 11, 2'b11, "R7 replaced at next fall");
    idle_all();

    // Strobe-first refresh and counter wrap
    do_cbr(1'b0, 1'b1);
    do_cbr(1'b1, 1'b1);
    chk(ref_count == 10'(exp_ref), "R10 count", ref_count, exp_ref);
    while (exp_ref != 1023) do_cbr(exp_ref[0], 1'b0);
    chk(ref_count == 10'd1023, "R10 top", ref_count, 1023);
    do_cbr(1'b0, 1'b1);
    chk(ref_count == 10'd0, "R10 wrap", ref_count, 0);

    // Random mix
    for (int n = 0; n < 150; n++) begin
      int r, c;
      logic [1:0] m;
      r = int'($urandom_range(15, 0));
      c = int'($urandom_range(15, 0));
      m = 2'($urandom_range(3, 1));
      case ($urandom_range(3, 0))
        0: do_write(r, c, m, 16'($urandom), 1'b0);
        1: do_write(r, c, m, 16'($urandom), 1'b1);
        2: do_cbr(1'($urandom), 1'b1);
        default: do_read(r, c, m);
      endcase
    end
    chk(ref_count == 10'(exp_ref), "R10 final count", ref_count, exp_ref);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule